// File: doc/BRIEF.md
# Access-to-clear interrupt status register

This block holds eight status flags for the local processor of an I/O controller. Each flag records one event: a pending request to interrupt the host, a SCSI controller interrupt, a DMA fault, DMA end-of-process in each direction, host support for sequential transfers, a host access to the control register, and a host access to the ID/vector register. Every flag is active-low. A 0 means the condition is pending and a 1 means it is idle or has been serviced.

Firmware services a flag by touching that flag's own local bus address. The access strobe may come from a read or from a write, and either one clears the flag. No write data is involved. The whole byte is always visible on a registered read port. Reading it at any address other than a clear address changes nothing.

The host-interrupt request flag is different from the others. Firmware asserts it with a strobe, and a host acknowledge strobe negates it. Event inputs are single-cycle strobes from the DMA controller, the SCSI chip and the host bus logic. Those blocks are outside this design.

Top module: `acc_clr_status`

## Requirements
- R1: A synchronous active-high reset drives all eight bits of `status_q` to 1 on the next clock edge.
- R2: A strobe on one of the event inputs drives its bit to 0 one clock later. The mapping is `vec_acc_ev` bit 0, `ctrl_acc_ev` bit 1, `seq_cap_ev` bit 2, `eop_m2f_ev` bit 3, `eop_f2m_ev` bit 4, `dma_fault_ev` bit 5 and `scsi_irq_ev` bit 6. All other bits are unchanged.
- R3: `acc_stb` high with `acc_addr` equal to a bit's clear address drives that bit to 1 one clock later. The clear addresses are 0x0488 for bit 0, 0x0489 for bit 1, 0x048A for bit 2, 0x048B for bit 3, 0x048C for bit 4, 0x048D for bit 5, 0x040D for bit 6 and 0x048F for bit 7.
- R4: An access to any other address, or a clear address presented while `acc_stb` is low, leaves every bit unchanged.
- R5: `vec_acc_ev` has no effect on bit 0 while `iack_cycle` is high.
- R6: `fw_host_req` drives bit 7 to 0 one clock later. Either `host_ack` or an access to 0x048F returns bit 7 to 1 one clock later.
- R7: If a bit's set event and its clear condition occur in the same cycle, the bit becomes 0.
- R8: A bit with neither a set event nor a clear condition keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | Local bus access strobe (read or write) |
| acc_addr | input | 16 | Local bus address |
| fw_host_req | input | 1 | Firmware strobe asserting the host interrupt request |
| host_ack | input | 1 | Host acknowledge strobe negating the request |
| scsi_irq_ev | input | 1 | SCSI controller interrupt event |
| dma_fault_ev | input | 1 | Peripheral fault during FIFO/memory DMA |
| eop_f2m_ev | input | 1 | DMA end-of-process, FIFO to memory |
| eop_m2f_ev | input | 1 | DMA end-of-process, memory to FIFO |
| seq_cap_ev | input | 1 | Host signals sequential-access support |
| ctrl_acc_ev | input | 1 | Host access to the control register |
| vec_acc_ev | input | 1 | Host access to the ID/vector register |
| iack_cycle | input | 1 | Current host access is an interrupt acknowledge cycle |
| status_q | output | 8 | Registered status byte, active-low flags |

## Verification
The assertions assume that every input is a clean 0 or 1 at each rising edge. They also assume that reset is held high for at least one edge before any event is observed. No assumption is made about which events occur together, so the checks treat simultaneous sets and clears as legal.

The stimulus first drives each event and each clear address on its own. It then applies deliberate set-and-clear collisions, near-miss addresses and strobe-less accesses. It ends with a long phase of random strobes, in which addresses are drawn mostly from the clear set. Every input changes only on the falling edge, so each sample taken on a rising edge is well defined.

// File: rtl/acc_clr_pkg.sv
package acc_clr_pkg;
  localparam int NFLAGS = 8;
  localparam int B_VEC   = 0;
  localparam int B_CTRL  = 1;
  localparam int B_SEQ   = 2;
  localparam int B_M2F   = 3;
  localparam int B_F2M   = 4;
  localparam int B_FAULT = 5;
  localparam int B_SCSI  = 6;
  localparam int B_HREQ  = 7;

  // Local address whose access services flag idx
  function automatic logic [15:0] clear_addr(input int idx);
    case (idx)
      B_SCSI:  clear_addr = 16'h040D;
      B_HREQ:  clear_addr = 16'h048F;
      default: clear_addr = 16'h0488 + 16'(idx);
    endcase
  endfunction
endpackage

// File: rtl/acc_clr_dec.sv
module acc_clr_dec #(
  parameter int ADDR_W = 16,
  parameter int NF     = acc_clr_pkg::NFLAGS
) (
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [NF-1:0]     hit
);
  for (genvar g = 0; g < NF; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(acc_clr_pkg::clear_addr(g));
    assign hit[g] = stb && (addr == MATCH);
  end
endmodule

// File: rtl/acc_clr_flag.sv
module acc_clr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_n
);
  // Active-low flag: a set event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        flag_n <= 1'b1;
    else if (set_i) flag_n <= 1'b0;
    else if (clr_i) flag_n <= 1'b1;
  end
endmodule

// File: rtl/acc_clr_status.sv
module acc_clr_status #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              fw_host_req,
  input  logic              host_ack,
  input  logic              scsi_irq_ev,
  input  logic              dma_fault_ev,
  input  logic              eop_f2m_ev,
  input  logic              eop_m2f_ev,
  input  logic              seq_cap_ev,
  input  logic              ctrl_acc_ev,
  input  logic              vec_acc_ev,
  input  logic              iack_cycle,
  output logic [7:0]        status_q
);
  import acc_clr_pkg::*;
  localparam int NF = NFLAGS;

  logic [NF-1:0] set_vec;
  logic [NF-1:0] hit_vec;
  logic [NF-1:0] clr_vec;
  logic [NF-1:0] flag_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[B_VEC]   = vec_acc_ev && !iack_cycle;
    set_vec[B_CTRL]  = ctrl_acc_ev;
    set_vec[B_SEQ]   = seq_cap_ev;
    set_vec[B_M2F]   = eop_m2f_ev;
    set_vec[B_F2M]   = eop_f2m_ev;
    set_vec[B_FAULT] = dma_fault_ev;
    set_vec[B_SCSI]  = scsi_irq_ev;
    set_vec[B_HREQ]  = fw_host_req;
  end

  acc_clr_dec #(.ADDR_W(ADDR_W), .NF(NF)) u_dec (
    .stb  (acc_stb),
    .addr (acc_addr),
    .hit  (hit_vec)
  );

  always_comb begin
    clr_vec         = hit_vec;
    clr_vec[B_HREQ] = hit_vec[B_HREQ] | host_ack;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    acc_clr_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_n (flag_vec[i])
    );
  end

  assign status_q = flag_vec;
endmodule

// File: rtl/acc_clr_status_chk.sv
module acc_clr_status_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_stb,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              fw_host_req,
  input logic              host_ack,
  input logic              scsi_irq_ev,
  input logic              dma_fault_ev,
  input logic              eop_f2m_ev,
  input logic              eop_m2f_ev,
  input logic              seq_cap_ev,
  input logic              ctrl_acc_ev,
  input logic              vec_acc_ev,
  input logic              iack_cycle,
  input logic [7:0]        status_q
);
  logic [7:0] ev;
  logic [7:0] clr;
  assign ev = {fw_host_req, scsi_irq_ev, dma_fault_ev, eop_f2m_ev,
               eop_m2f_ev, seq_cap_ev, ctrl_acc_ev, vec_acc_ev && !iack_cycle};

  for (genvar i = 0; i < 8; i++) begin : g_c
    assign clr[i] = (acc_stb && acc_addr == ADDR_W'(acc_clr_pkg::clear_addr(i)))
                    || (i == 7 && host_ack);

    // R2 R6 R7
    set_low_chk: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> !status_q[i]);
    // R3 R6
    clear_high_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !ev[i]) |=> status_q[i]);
    // R4 R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr[i] && !ev[i]) |=> $stable(status_q[i]));
  end

  // R1
  reset_ones_chk: assert property (@(posedge clk) rst |=> (status_q == 8'hFF));
  // R5
  iack_block_chk: assert property (@(posedge clk) disable iff (rst)
    (iack_cycle && !clr[0]) |=> $stable(status_q[0]));
endmodule

bind acc_clr_status acc_clr_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_addr(acc_addr),
  .fw_host_req(fw_host_req), .host_ack(host_ack), .scsi_irq_ev(scsi_irq_ev),
  .dma_fault_ev(dma_fault_ev), .eop_f2m_ev(eop_f2m_ev), .eop_m2f_ev(eop_m2f_ev),
  .seq_cap_ev(seq_cap_ev), .ctrl_acc_ev(ctrl_acc_ev), .vec_acc_ev(vec_acc_ev),
  .iack_cycle(iack_cycle), .status_q(status_q)
);

// File: tb/sim_acc_clr_status.sv
`timescale 1ns/1ps
module sim_acc_clr_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_stb = 1'b0;
  logic [15:0] acc_addr = '0;
  logic fw_host_req = 0, host_ack = 0, scsi_irq_ev = 0, dma_fault_ev = 0;
  logic eop_f2m_ev = 0, eop_m2f_ev = 0, seq_cap_ev = 0, ctrl_acc_ev = 0;
  logic vec_acc_ev = 0, iack_cycle = 0;
  logic [7:0] status_q;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit [7:0] model = 8'hFF;

  always #2 clk = ~clk;

  acc_clr_status u0 (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_addr(acc_addr),
    .fw_host_req(fw_host_req), .host_ack(host_ack), .scsi_irq_ev(scsi_irq_ev),
    .dma_fault_ev(dma_fault_ev), .eop_f2m_ev(eop_f2m_ev), .eop_m2f_ev(eop_m2f_ev),
    .seq_cap_ev(seq_cap_ev), .ctrl_acc_ev(ctrl_acc_ev), .vec_acc_ev(vec_acc_ev),
    .iack_cycle(iack_cycle), .status_q(status_q)
  );

  function automatic bit [15:0] svc_addr(input int b);
    case (b)
      0: return 16'h0488;  1: return 16'h0489;  2: return 16'h048A;
      3: return 16'h048B;  4: return 16'h048C;  5: return 16'h048D;
      6: return 16'h040D;  default: return 16'h048F;
    endcase
  endfunction

  task automatic quiet();
    acc_stb = 0; acc_addr = '0; fw_host_req = 0; host_ack = 0; scsi_irq_ev = 0;
    dma_fault_ev = 0; eop_f2m_ev = 0; eop_m2f_ev = 0; seq_cap_ev = 0;
    ctrl_acc_ev = 0; vec_acc_ev = 0; iack_cycle = 0; rst = 0;
  endtask

  task automatic pulse_event(input int b);
    case (b)
      0: vec_acc_ev = 1;  1: ctrl_acc_ev = 1;  2: seq_cap_ev = 1;
      3: eop_m2f_ev = 1;  4: eop_f2m_ev = 1;   5: dma_fault_ev = 1;
      6: scsi_irq_ev = 1; default: fw_host_req = 1;
    endcase
  endtask

  // Inputs are already set (at a falling edge); advance one clock and compare
  task automatic step(input string tag);
    bit [7:0] s, c;
    s = {fw_host_req, scsi_irq_ev, dma_fault_ev, eop_f2m_ev, eop_m2f_ev,
         seq_cap_ev, ctrl_acc_ev, (vec_acc_ev && !iack_cycle)};
    for (int b = 0; b < 8; b++) c[b] = acc_stb && (acc_addr == svc_addr(b));
    c[7] = c[7] | host_ack;
    if (rst) model = 8'hFF;
    else for (int b = 0; b < 8; b++) begin
      if (s[b]) model[b] = 1'b0;
      else if (c[b]) model[b] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (status_q !== model) begin
      fails++;
      $display("FAIL %s: status_q=%h expected=%h", tag, status_q, model);
    end
    quiet();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: status_q=%h expected=%h", status_q, model);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    @(negedge clk);
    rst = 1; step("R1 reset");
    // R2: each event alone
    for (int b = 0; b < 7; b++) begin pulse_event(b); step("R2 event set"); end
    // R3: clear each bit via its own address
    for (int b = 0; b < 8; b++) begin acc_stb = 1; acc_addr = svc_addr(b); step("R3 clear"); end
    // R4: near-miss addresses and no-strobe
    for (int b = 0; b < 7; b++) begin pulse_event(b); step("R2 reload"); end
    acc_stb = 1; acc_addr = 16'h048E; step("R4 unused addr");
    acc_stb = 1; acc_addr = 16'h040C; step("R4 near addr");
    acc_stb = 1; acc_addr = 16'h0888; step("R4 alias addr");
    acc_stb = 0; acc_addr = 16'h0489; step("R4 no strobe");
    step("R8 idle hold");
    // R5: vector access during interrupt acknowledge
    acc_stb = 1; acc_addr = 16'h0488; step("R3 clear bit0");
    vec_acc_ev = 1; iack_cycle = 1; step("R5 iack blocks");
    vec_acc_ev = 1; iack_cycle = 0; step("R5 normal vector set");
    // R6: host request flag
    fw_host_req = 1; step("R6 fw request");
    step("R8 request holds");
    host_ack = 1; step("R6 host ack");
    fw_host_req = 1; step("R6 fw request again");
    acc_stb = 1; acc_addr = 16'h048F; step("R6 addr negate");
    // R7: set and clear collide
    eop_f2m_ev = 1; acc_stb = 1; acc_addr = 16'h048C; step("R7 collide bit4");
    fw_host_req = 1; host_ack = 1; step("R7 collide ack");
    scsi_irq_ev = 1; acc_stb = 1; acc_addr = 16'h040D; step("R7 collide bit6");
    // R1 mid-run reset
    rst = 1; step("R1 reset again");
    // Random mix: R2 R3 R4 R7 R8
    for (int n = 0; n < 2000; n++) begin
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 5) == 0) pulse_event(b);
      host_ack = ($urandom_range(0, 7) == 0);
      iack_cycle = $urandom_range(0, 1);
      acc_stb = $urandom_range(0, 1);
      if ($urandom_range(0, 3) != 0) acc_addr = svc_addr(int'($urandom_range(0, 7)));
      else acc_addr = 16'($urandom);
      rst = ($urandom_range(0, 199) == 0);
      step("R8 random mix");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule